// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block receives 8-bit frames from a serial data line, one bit per serial clock edge. The serial clock can come from one of two places. The block can generate it from the system clock at a selectable rate and drive it out to the sending device. It can also take it from an external pin, resynchronised into the system clock domain. A write strobe loads a small control word: operating mode, start/stop request, sampling edge, bit order and clock source. The host sees busy, shift-enable, receive-done and overrun flags. It also sees a receive buffer and a single-cycle completion interrupt.

With the generated clock, the block stops its clock after every byte and waits until the host reads the buffer. This way no byte can be lost. With an external clock the sender sets the pace, so the block keeps shifting. If a second frame completes before the first was collected, the block flags an overrun. A stop request that arrives in the middle of a frame is deferred until that frame is complete. Writing the off mode abandons the frame at once.

Top module: `sync_byte_rx`

## Requirements
- R1: After reset, busy, shift-enable, receive-done, overrun and the interrupt are all 0. The buffer reads 0, the clock select is 0 (internal), `sck_oe` is 1 and `sck_out` idles high.
- R2: While idle, a control write with mode 2'b10 and start=1 sets busy and shift-enable on the following cycle.
- R3: After 8 sampling edges, the assembled byte is copied to `rx_buf`, receive-done is set and `irq` pulses high for exactly one cycle. With `ctl_lsb`=0 the first received bit becomes bit 7. With `ctl_lsb`=1 the first received bit becomes bit 0.
- R4: With `ctl_edge`=0 data is sampled on rising serial clock edges. With `ctl_edge`=1 data is sampled on falling serial clock edges.
- R5: With clock select 0 to 6 (internal), `sck_out` toggles every BASE_HALF<<select system cycles. After each byte, shift-enable clears and `sck_out` stays high until the buffer is read. That read sets shift-enable again and the clock resumes.
- R6: Clock select 3'b111 selects the external clock. `sck_oe` is then 0 and `sck_out` is 1. Reception continues with no buffer read in between. A frame that completes while receive-done is still set raises the overrun flag and leaves `rx_buf` unchanged.
- R7: A buffer read clears receive-done. A status read clears overrun.
- R8: While busy, control writes are ignored for the edge, bit-order and clock-select fields, and a write of mode 2'b10 with start=1 has no effect.
- R9: While busy, a write with start=0 stops reception on the next cycle with no interrupt, provided shift-enable is 0 or no bit of the current frame has yet been sampled.
- R10: While busy, a write with start=0 when shift-enable is 1 and part of a frame has been sampled lets that frame finish. The frame is then stored, `irq` pulses and busy clears.
- R11: While busy, a write with mode 2'b00 aborts at once. Busy clears with no interrupt, and `rx_buf` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Mode: 2'b10 receive, 2'b00 off |
| ctl_start | input | 1 | 1 starts, 0 requests stop |
| ctl_edge | input | 1 | 0 rising-edge sampling, 1 falling-edge sampling |
| ctl_lsb | input | 1 | 0 MSB first, 1 LSB first |
| ctl_csel | input | 3 | 0 to 6 internal rate, 7 external clock |
| buf_rd | input | 1 | Receive buffer read strobe |
| stat_rd | input | 1 | Status read strobe |
| sck_in | input | 1 | External serial clock |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| rx_buf | output | 8 | Receive buffer |
| st_busy | output | 1 | Busy flag |
| st_shen | output | 1 | Shift-enable flag |
| st_done | output | 1 | Receive-done flag |
| st_ovr | output | 1 | Overrun flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with BASE_HALF=4 and the default two-stage synchronizer and 8-bit frame. With these values the internal half period is 4 cycles at select 0 and 8 cycles at select 1, so both rates can be measured exactly in a short run. A byte at the internal rate takes only about 64 cycles. That leaves room for the wait, deferred-stop and abort sequences, for both edge and order settings, and for several external frames that push the block into overrun.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam int CSEL_W = 3;
    localparam logic [CSEL_W-1:0] CSEL_EXT = '1;
    localparam logic [1:0] MODE_RX  = 2'b10;
    localparam logic [1:0] MODE_OFF = 2'b00;

    typedef struct packed {
        logic              edge_fall;
        logic              lsb_first;
        logic [CSEL_W-1:0] csel;
    } sbr_cfg_t;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic sdi_in,
    output logic sdi_s,
    output logic sck_rise,
    output logic sck_fall
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] sdi;
        logic              sck_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.sck      = {q.sck[STAGES-2:0], sck_in};
        d.sdi      = {q.sdi[STAGES-2:0], sdi_in};
        d.sck_prev = q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sck: '1, sdi: '0, sck_prev: 1'b1};
        else        q <= d;
    end

    assign sdi_s    = q.sdi[STAGES-1];
    assign sck_rise = q.sck[STAGES-1] & ~q.sck_prev;
    assign sck_fall = ~q.sck[STAGES-1] & q.sck_prev;
endmodule

// File: rtl/sbr_clkgen.sv
module sbr_clkgen import sbr_pkg::*; #(
    parameter int BASE_HALF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [CSEL_W-1:0] csel,
    output logic              sck,
    output logic              rise_ev,
    output logic              fall_ev
);
    localparam int MAX_HALF = BASE_HALF << ((1 << CSEL_W) - 1);
    localparam int DIV_W    = $clog2(MAX_HALF + 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
    } gen_t;

    gen_t q, d;
    logic [DIV_W-1:0] lim;
    logic active, tick;

    always_comb begin
        lim    = DIV_W'(BASE_HALF) << csel;
        active = run_req | ~q.sck;
        tick   = active && (q.cnt == lim - 1'b1);
        d      = q;
        if (!active)   d.cnt = '0;
        else if (tick) begin
            d.cnt = '0;
            d.sck = ~q.sck;
        end else       d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, sck: 1'b1};
        else        q <= d;
    end

    assign sck     = q.sck;
    assign rise_ev = tick & ~q.sck;
    assign fall_ev = tick & q.sck;

    assert_halt_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_req && q.sck) |=> q.sck);
endmodule

// File: rtl/sbr_core.sv
module sbr_core import sbr_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_mode,
    input  logic              ctl_start,
    input  logic              ctl_edge,
    input  logic              ctl_lsb,
    input  logic [CSEL_W-1:0] ctl_csel,
    input  logic              buf_rd,
    input  logic              stat_rd,
    input  logic              sdi_s,
    input  logic              ext_rise,
    input  logic              ext_fall,
    input  logic              int_rise,
    input  logic              int_fall,
    output sbr_cfg_t          cfg,
    output logic              busy,
    output logic              shen,
    output logic              done,
    output logic              ovr,
    output logic              irq,
    output logic [DATA_W-1:0] rx_buf
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        sbr_cfg_t          cfg;
        logic              busy;
        logic              shen;
        logic              done;
        logic              ovr;
        logic              stop_pend;
        logic              irq;
        logic [CNT_W-1:0]  bcnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rbuf;
    } core_t;

    core_t q, d;
    logic ext, smp, last;
    logic [DATA_W-1:0] nxt_sh;

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        ext    = (q.cfg.csel == CSEL_EXT);
        smp    = q.busy & (ext ? (q.cfg.edge_fall ? ext_fall : ext_rise)
                               : (q.cfg.edge_fall ? int_fall : int_rise));
        nxt_sh = q.cfg.lsb_first ? {sdi_s, q.shreg[DATA_W-1:1]}
                                 : {q.shreg[DATA_W-2:0], sdi_s};
        last   = (q.bcnt == CNT_W'(DATA_W - 1));

        if (buf_rd) begin
            d.done = 1'b0;
            if (q.busy && !ext && !q.shen) d.shen = 1'b1;
        end
        if (stat_rd) d.ovr = 1'b0;

        if (smp) begin
            d.shreg = nxt_sh;
            d.bcnt  = q.bcnt + 1'b1;
            if (last) begin
                d.bcnt = '0;
                d.irq  = 1'b1;
                if (q.done && !buf_rd) d.ovr = 1'b1;
                else begin
                    d.rbuf = nxt_sh;
                    d.done = 1'b1;
                end
                if (!ext) d.shen = 1'b0;
                if (q.stop_pend) begin
                    d.busy      = 1'b0;
                    d.shen      = 1'b0;
                    d.stop_pend = 1'b0;
                end
            end
        end

        if (ctl_wr) begin
            if (q.busy) begin
                if (ctl_mode == MODE_OFF) begin
                    d.busy      = 1'b0;
                    d.shen      = 1'b0;
                    d.stop_pend = 1'b0;
                    d.bcnt      = '0;
                    d.irq       = 1'b0;
                end else if (!ctl_start) begin
                    if (!q.shen || q.bcnt == '0) begin
                        d.busy = 1'b0;
                        d.shen = 1'b0;
                        d.bcnt = '0;
                    end else d.stop_pend = 1'b1;
                end
            end else begin
                d.cfg = '{edge_fall: ctl_edge, lsb_first: ctl_lsb, csel: ctl_csel};
                if (ctl_start && ctl_mode == MODE_RX) begin
                    d.busy      = 1'b1;
                    d.shen      = 1'b1;
                    d.stop_pend = 1'b0;
                    d.bcnt      = '0;
                    d.shreg     = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg    = q.cfg;
    assign busy   = q.busy;
    assign shen   = q.shen;
    assign done   = q.done;
    assign ovr    = q.ovr;
    assign irq    = q.irq;
    assign rx_buf = q.rbuf;

    assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq);
    assert_irq_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> q.done);
    assert_shen_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.shen |-> q.busy);
    assert_ovr_keeps_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $stable(q.rbuf));
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> $stable(q.cfg));
    assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_mode == MODE_OFF && q.busy) |=> (!q.busy && !q.irq));
endmodule

// File: rtl/sync_byte_rx.sv
module sync_byte_rx import sbr_pkg::*; #(
    parameter int DATA_W      = 8,
    parameter int BASE_HALF   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_mode,
    input  logic              ctl_start,
    input  logic              ctl_edge,
    input  logic              ctl_lsb,
    input  logic [CSEL_W-1:0] ctl_csel,
    input  logic              buf_rd,
    input  logic              stat_rd,
    input  logic              sck_in,
    input  logic              sdi,
    output logic              sck_out,
    output logic              sck_oe,
    output logic [DATA_W-1:0] rx_buf,
    output logic              st_busy,
    output logic              st_shen,
    output logic              st_done,
    output logic              st_ovr,
    output logic              irq
);
    sbr_cfg_t cfg;
    logic sdi_s, ext_rise, ext_fall, int_rise, int_fall, sck_int, run_req;

    sbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi_in(sdi),
        .sdi_s(sdi_s), .sck_rise(ext_rise), .sck_fall(ext_fall)
    );

    assign sck_oe  = (cfg.csel != CSEL_EXT);
    assign run_req = st_busy & st_shen & sck_oe;

    sbr_clkgen #(.BASE_HALF(BASE_HALF)) u_gen (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .csel(cfg.csel),
        .sck(sck_int), .rise_ev(int_rise), .fall_ev(int_fall)
    );

    sbr_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
        .ctl_start(ctl_start), .ctl_edge(ctl_edge), .ctl_lsb(ctl_lsb),
        .ctl_csel(ctl_csel), .buf_rd(buf_rd), .stat_rd(stat_rd),
        .sdi_s(sdi_s), .ext_rise(ext_rise), .ext_fall(ext_fall),
        .int_rise(int_rise), .int_fall(int_fall), .cfg(cfg),
        .busy(st_busy), .shen(st_shen), .done(st_done), .ovr(st_ovr),
        .irq(irq), .rx_buf(rx_buf)
    );

    assign sck_out = sck_oe ? sck_int : 1'b1;
endmodule

// File: tb/sync_byte_rx_test.sv
module sync_byte_rx_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_wr = 0, ctl_start = 0, ctl_edge = 0, ctl_lsb = 0;
    logic [1:0] ctl_mode = 0;
    logic [2:0] ctl_csel = 0;
    logic buf_rd = 0, stat_rd = 0, sck_in = 1, sdi = 0, kill = 0;
    logic sck_out, sck_oe, st_busy, st_shen, st_done, st_ovr, irq;
    logic [7:0] rx_buf;
    int n_chk = 0, n_bad = 0, irq_cnt = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    sync_byte_rx #(.BASE_HALF(4)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
        .ctl_start(ctl_start), .ctl_edge(ctl_edge), .ctl_lsb(ctl_lsb),
        .ctl_csel(ctl_csel), .buf_rd(buf_rd), .stat_rd(stat_rd),
        .sck_in(sck_in), .sdi(sdi), .sck_out(sck_out), .sck_oe(sck_oe),
        .rx_buf(rx_buf), .st_busy(st_busy), .st_shen(st_shen),
        .st_done(st_done), .st_ovr(st_ovr), .irq(irq)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // scoreboard monitor: every interrupt must match the next queued buffer value (R3)
    always @(negedge clk) begin
        if (rst_n && irq) begin
            irq_cnt++;
            if (exp_q.size() == 0) chk("R3", "unexpected irq", 1, 0);
            else chk("R3", "rx_buf at irq", {24'b0, rx_buf}, {24'b0, exp_q.pop_front()});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("WDOG", "watchdog expired", 1, 0);
        summary();
        $finish;
    end

    task automatic wr_ctl(logic [1:0] m, logic s, logic e, logic l, logic [2:0] c);
        @(negedge clk);
        ctl_wr = 1; ctl_mode = m; ctl_start = s; ctl_edge = e; ctl_lsb = l; ctl_csel = c;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic pulse_rd(logic which_stat);
        @(negedge clk);
        if (which_stat) stat_rd = 1; else buf_rd = 1;
        @(negedge clk);
        stat_rd = 0; buf_rd = 0;
    endtask

    task automatic wait_irq(int n);
        int t = 0;
        while (irq_cnt < n && t < 5000) begin @(negedge clk); t++; end
        chk("R3", "irq count reached", irq_cnt, n);
    endtask

    // slave for the generated clock: present next bit after each sampling edge
    task automatic int_slave(logic [7:0] b, logic lsb, logic edg);
        logic prev;
        logic hit;
        prev = sck_out;
        for (int i = 0; i < 8; i++) begin
            sdi = lsb ? b[i] : b[7-i];
            hit = 0;
            while (!hit && !kill) begin
                @(negedge clk);
                hit  = (sck_out != prev) && (sck_out == !edg);
                prev = sck_out;
            end
            if (kill) break;
        end
    endtask

    task automatic ext_send(logic [7:0] b, logic lsb, logic edg);
        for (int i = 0; i < 8; i++) begin
            sdi = lsb ? b[i] : b[7-i];
            sck_in = edg;
            repeat (6) @(negedge clk);
            sck_in = !edg;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic measure_half(int exp, string req);
        logic prev;
        int n;
        prev = sck_out;
        forever begin
            @(negedge clk);
            if (prev && !sck_out) break;
            prev = sck_out;
        end
        n = 0;
        while (!sck_out && n < 100) begin @(negedge clk); n++; end
        chk(req, "internal half period", n, exp);
    endtask

    task automatic hold_high(int cycles, string req);
        int toggles = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sck_out !== 1'b1) toggles++;
        end
        chk(req, "sck_out held high", toggles, 0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", st_busy, 0);
        chk("R1", "shen", st_shen, 0);
        chk("R1", "done/ovr/irq", {st_done, st_ovr, irq}, 0);
        chk("R1", "rx_buf", rx_buf, 0);
        chk("R1", "sck_out/sck_oe", {sck_out, sck_oe}, 2'b11);

        // internal, rising, MSB first, select 0
        exp_q.push_back(8'hA5);
        fork int_slave(8'hA5, 0, 0); join_none
        wr_ctl(2'b10, 1, 0, 0, 3'd0);
        chk("R2", "busy+shen after start", {st_busy, st_shen}, 2'b11);
        measure_half(4, "R5");
        wait_irq(1);
        @(negedge clk);
        chk("R5", "shen cleared in wait", st_shen, 0);
        chk("R3", "done set", st_done, 1);
        hold_high(40, "R5");

        // resume by reading buffer
        exp_q.push_back(8'h3C);
        fork int_slave(8'h3C, 0, 0); join_none
        pulse_rd(0);
        chk("R7", "done cleared by buffer read", st_done, 0);
        chk("R5", "shen restored by read", st_shen, 1);
        wait_irq(2);

        // R8: config write while busy is ignored (order/edge/rate unchanged)
        wr_ctl(2'b10, 1, 1, 1, 3'd1);
        chk("R8", "still waiting", {st_busy, st_shen}, 2'b10);
        exp_q.push_back(8'h1E);
        fork int_slave(8'h1E, 0, 0); join_none
        pulse_rd(0);
        measure_half(4, "R8");
        wait_irq(3);

        // R9: stop while waiting (shen=0) is immediate with no irq
        wr_ctl(2'b10, 0, 0, 0, 3'd0);
        chk("R9", "busy/shen after stop", {st_busy, st_shen}, 2'b00);
        hold_high(50, "R9");
        chk("R9", "no irq on immediate stop", irq_cnt, 3);
        pulse_rd(0);

        // R4 falling edge, LSB first, select 1
        exp_q.push_back(8'hC6);
        fork int_slave(8'hC6, 1, 1); join_none
        wr_ctl(2'b10, 1, 1, 1, 3'd1);
        measure_half(8, "R5");
        wait_irq(4);
        chk("R4", "falling LSB byte", rx_buf, 8'hC6);

        // R10 deferred stop
        exp_q.push_back(8'h5B);
        fork int_slave(8'h5B, 1, 1); join_none
        pulse_rd(0);
        for (int k = 0; k < 3; k++) @(negedge sck_out);
        wr_ctl(2'b10, 0, 1, 1, 3'd1);
        chk("R10", "busy held during deferred stop", st_busy, 1);
        wait_irq(5);
        @(negedge clk);
        chk("R10", "busy cleared after frame", st_busy, 0);
        chk("R10", "byte stored", rx_buf, 8'h5B);
        repeat (20) @(negedge clk);
        chk("R10", "clock back idle", sck_out, 1);
        pulse_rd(0);

        // R11 abort mid-frame
        fork int_slave(8'hFF, 0, 0); join_none
        wr_ctl(2'b10, 1, 0, 0, 3'd0);
        for (int k = 0; k < 3; k++) @(posedge sck_out);
        wr_ctl(2'b00, 1, 0, 0, 3'd0);
        chk("R11", "busy cleared on abort", {st_busy, st_shen}, 2'b00);
        repeat (60) @(negedge clk);
        chk("R11", "no irq on abort", irq_cnt, 5);
        chk("R11", "rx_buf unchanged", rx_buf, 8'h5B);
        kill = 1;
        repeat (5) @(negedge clk);
        kill = 0;

        // R6 external, rising, MSB first
        sck_in = 1;
        repeat (5) @(negedge clk);
        wr_ctl(2'b10, 1, 0, 0, 3'd7);
        chk("R6", "sck_oe/sck_out external", {sck_oe, sck_out}, 2'b01);
        exp_q.push_back(8'h69);
        ext_send(8'h69, 0, 0);
        wait_irq(6);
        base = irq_cnt;
        exp_q.push_back(8'h69);
        ext_send(8'h96, 0, 0);
        wait_irq(base + 1);
        @(negedge clk);
        chk("R6", "overrun flag", st_ovr, 1);
        chk("R6", "buffer kept on overrun", rx_buf, 8'h69);
        chk("R6", "no wait in external mode", {st_busy, st_shen}, 2'b11);
        pulse_rd(1);
        chk("R7", "status read clears overrun", st_ovr, 0);
        pulse_rd(0);
        exp_q.push_back(8'h0F);
        ext_send(8'h0F, 0, 0);
        wait_irq(base + 2);
        @(negedge clk);
        chk("R6", "next external byte", rx_buf, 8'h0F);
        wr_ctl(2'b10, 0, 0, 0, 3'd7);
        chk("R9", "immediate stop between frames", st_busy, 0);
        pulse_rd(0);

        // external falling, LSB first
        sck_in = 0;
        repeat (5) @(negedge clk);
        wr_ctl(2'b10, 1, 1, 1, 3'd7);
        exp_q.push_back(8'hB2);
        ext_send(8'hB2, 1, 1);
        wait_irq(base + 3);
        @(negedge clk);
        chk("R4", "external falling LSB byte", rx_buf, 8'hB2);

        repeat (10) @(negedge clk);
        chk("R3", "scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule